// File: doc/BRIEF.md
# CPU Status and Banked Register Unit

This unit holds the architectural state of a small CPU that sits outside the datapath. That state is an 11-bit flag word, two complete banks of general and address registers, and a pair of 16-bit stack pointers, one for user code and one for interrupt code. The decoder and the ALU around the unit drive its inputs. ALU results come in with an update strobe and set the condition flags. Register traffic goes through one write port and one read port, and the two address registers of each bank can also be moved together as one double-width register. Software loads the flag word through an explicit write port.

Two flag bits steer the rest of the state. The bank-select flag picks which register bank every read and write reaches. The stack-select flag picks which stack pointer is visible and which one takes writes. When the interrupt controller acknowledges a request, the unit saves the flag word as it stood before the acknowledge. It then clears the interrupt-enable flag and the stack-select flag, so that the handler runs masked and on the interrupt stack.

Top module: `cpu_state_unit`

## Requirements
- R1: While reset is asserted and after it is released, every output reads zero. This covers flags, flag_save, sp_out, rd_data and pair_rd_data. With stack-select at 0 the interrupt stack pointer is the active one.
- R2: The flag bit positions are carry=0, debug=1, zero=2, sign=3, bank=4, overflow=5, irq-enable=6, stack-select=7. A cycle with alu_upd high, and with no flag write or acknowledge in that cycle, updates four bits on the next clock: carry takes alu_carry, zero takes (alu_result == 0), sign takes the most significant bit of alu_result, and overflow takes alu_ovf. All other flag bits keep their values.
- R3: A cycle with flag_wr_en high loads flag_wr_data into the writable flag bits on the next clock, and any alu_upd in the same cycle is discarded.
- R4: The debug bit (bit 1) and the reserved bits 10:8 always read 0. Writes to them have no effect.
- R5: A cycle with int_ack high clears irq-enable (bit 6) and stack-select (bit 7) on the next clock. This overrides a flag write in the same cycle, which still sets the other bits.
- R6: On the clock that ends an int_ack cycle, flag_save captures the flag word as it was during that cycle. At all other times flag_save holds its value.
- R7: With bank=0 all register reads and writes use bank 0, and with bank=1 they use bank 1. The bank that is not selected is left unchanged.
- R8: Register index i < NUM_GPR is a general register, index NUM_GPR is address register lo, and index NUM_GPR+1 is address register hi. pair_rd_data is {hi, lo}, and pair_wr_en loads both halves. A pair write wins over a single write to lo or hi in the same cycle. A write to any higher index is ignored, and a read from a higher index returns 0.
- R9: sp_out shows the user stack pointer when stack-select=1 and the interrupt stack pointer when stack-select=0. sp_wr_en writes only the pointer that is currently selected, and the value appears on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alu_upd | input | 1 | Take ALU flag results this cycle |
| alu_result | input | DATA_W | ALU result value |
| alu_carry | input | 1 | ALU carry, borrow or shifted-out bit |
| alu_ovf | input | 1 | ALU signed overflow |
| flag_wr_en | input | 1 | Explicit flag word write |
| flag_wr_data | input | 11 | Flag word to write |
| int_ack | input | 1 | Interrupt acknowledge strobe |
| wr_en | input | 1 | Single register write |
| wr_idx | input | IDX_W | Single write register index |
| wr_data | input | DATA_W | Single write data |
| pair_wr_en | input | 1 | Address pair write |
| pair_wr_data | input | 2*DATA_W | Address pair data {hi, lo} |
| rd_idx | input | IDX_W | Read register index |
| sp_wr_en | input | 1 | Active stack pointer write |
| sp_wr_data | input | DATA_W | Stack pointer write data |
| rd_data | output | DATA_W | Read data of the selected bank |
| pair_rd_data | output | 2*DATA_W | Address pair of the selected bank |
| flags | output | 11 | Current flag word |
| flag_save | output | 11 | Flag word saved at the last acknowledge |
| sp_out | output | DATA_W | Active stack pointer |

## Verification
The bench builds the unit with DATA_W=16 and NUM_GPR=4. That gives six registers per bank behind a 3-bit index, so indices 6 and 7 are out of range and the ignore-and-read-zero rule of R8 can be exercised. Sixteen-bit results let one table drive each condition flag alone and in combination: zero, most-significant-bit negative, and carry and overflow with and without a zero result. The same set-up covers the priority collisions (ALU update against flag write, flag write against acknowledge) and the effect of the bank and stack-select bits on what the ports show.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;
  localparam int FLAG_W = 11;
  localparam int FB_C = 0;
  localparam int FB_D = 1;
  localparam int FB_Z = 2;
  localparam int FB_S = 3;
  localparam int FB_B = 4;
  localparam int FB_O = 5;
  localparam int FB_I = 6;
  localparam int FB_U = 7;
  localparam logic [FLAG_W-1:0] FLAG_WMASK = 11'h0FD;

  typedef logic [FLAG_W-1:0] flags_t;

  // Replace the four condition bits with an ALU outcome.
  function automatic flags_t apply_alu(flags_t f, logic is_zero, logic is_neg,
                                       logic carry, logic ovf);
    flags_t n;
    n       = f;
    n[FB_C] = carry;
    n[FB_Z] = is_zero;
    n[FB_S] = is_neg;
    n[FB_O] = ovf;
    return n;
  endfunction

  // Effect of an interrupt acknowledge: masked, interrupt stack.
  function automatic flags_t ack_clear(flags_t f);
    flags_t n;
    n       = f;
    n[FB_I] = 1'b0;
    n[FB_U] = 1'b0;
    return n;
  endfunction
endpackage

// File: rtl/cpu_flag_reg.sv
module cpu_flag_reg
  import cpu_state_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alu_take,
  input  logic              result_zero,
  input  logic              result_neg,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              flag_wr_en,
  input  logic [FLAG_W-1:0] flag_wr_data,
  input  logic              ack_evt,
  output logic [FLAG_W-1:0] flags_q,
  output logic [FLAG_W-1:0] save_q
);
  flags_t after_alu;
  flags_t after_wr;
  flags_t flags_d;

  always_comb begin
    after_alu = alu_take ? apply_alu(flags_q, result_zero, result_neg, alu_carry, alu_ovf)
                         : flags_q;
    after_wr  = flag_wr_en ? flag_wr_data : after_alu;
    flags_d   = (ack_evt ? ack_clear(after_wr) : after_wr) & FLAG_WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      save_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (ack_evt) save_q <= flags_q;
    end
  end
endmodule

// File: rtl/cpu_reg_bank.sv
module cpu_reg_bank #(
  parameter int DATA_W  = 16,
  parameter int NUM_GPR = 4,
  localparam int NREG   = NUM_GPR + 2,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                pair_wr_en,
  input  logic [2*DATA_W-1:0] pair_wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] pair_rd_data
);
  localparam int LO_IDX = NUM_GPR;
  localparam int HI_IDX = NUM_GPR + 1;

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         regs_q[i] <= '0;
      else if (pair_wr_en && i == LO_IDX) regs_q[i] <= pair_wr_data[DATA_W-1:0];
      else if (pair_wr_en && i == HI_IDX) regs_q[i] <= pair_wr_data[2*DATA_W-1:DATA_W];
      else if (wr_en && wr_idx == IDX_W'(i)) regs_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDX_W'(i)) rd_data = regs_q[i];
  end

  assign pair_rd_data = {regs_q[HI_IDX], regs_q[LO_IDX]};
endmodule

// File: rtl/cpu_stack_ptrs.sv
module cpu_stack_ptrs #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_user,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sp_out
);
  logic [DATA_W-1:0] usp_q;
  logic [DATA_W-1:0] isp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usp_q <= '0;
      isp_q <= '0;
    end else if (wr_en) begin
      if (sel_user) usp_q <= wr_data;
      else          isp_q <= wr_data;
    end
  end

  assign sp_out = sel_user ? usp_q : isp_q;
endmodule

// File: rtl/cpu_state_unit.sv
module cpu_state_unit
  import cpu_state_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int NUM_GPR = 4,
  localparam int NREG   = NUM_GPR + 2,
  localparam int IDX_W  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alu_upd,
  input  logic [DATA_W-1:0]   alu_result,
  input  logic                alu_carry,
  input  logic                alu_ovf,
  input  logic                flag_wr_en,
  input  logic [FLAG_W-1:0]   flag_wr_data,
  input  logic                int_ack,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                pair_wr_en,
  input  logic [2*DATA_W-1:0] pair_wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                sp_wr_en,
  input  logic [DATA_W-1:0]   sp_wr_data,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] pair_rd_data,
  output logic [FLAG_W-1:0]   flags,
  output logic [FLAG_W-1:0]   flag_save,
  output logic [DATA_W-1:0]   sp_out
);
  // Named internal events, used by the bound checker.
  logic ack_evt;
  logic alu_take;
  logic result_zero;
  logic result_neg;
  logic bank_sel;

  assign ack_evt     = int_ack;
  assign alu_take    = alu_upd & ~flag_wr_en;
  assign result_zero = (alu_result == '0);
  assign result_neg  = alu_result[DATA_W-1];
  assign bank_sel    = flags[FB_B];

  cpu_flag_reg #(.DATA_W(DATA_W)) flag_i (
    .clk, .rst_n, .alu_take, .result_zero, .result_neg,
    .alu_carry, .alu_ovf, .flag_wr_en, .flag_wr_data, .ack_evt,
    .flags_q(flags), .save_q(flag_save)
  );

  logic [DATA_W-1:0]   bank_rd   [2];
  logic [2*DATA_W-1:0] bank_pair [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic hit;
    assign hit = (bank_sel == 1'(g));
    cpu_reg_bank #(.DATA_W(DATA_W), .NUM_GPR(NUM_GPR)) bank_i (
      .clk, .rst_n,
      .wr_en(wr_en & hit), .wr_idx, .wr_data,
      .pair_wr_en(pair_wr_en & hit), .pair_wr_data,
      .rd_idx, .rd_data(bank_rd[g]), .pair_rd_data(bank_pair[g])
    );
  end

  assign rd_data      = bank_rd[bank_sel];
  assign pair_rd_data = bank_pair[bank_sel];

  cpu_stack_ptrs #(.DATA_W(DATA_W)) sp_i (
    .clk, .rst_n, .sel_user(flags[FB_U]),
    .wr_en(sp_wr_en), .wr_data(sp_wr_data), .sp_out
  );
endmodule

// File: rtl/cpu_state_chk.sv
module cpu_state_chk
  import cpu_state_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alu_take,
  input logic              ack_evt,
  input logic [DATA_W-1:0] alu_result,
  input logic              alu_carry,
  input logic              alu_ovf,
  input logic              flag_wr_en,
  input logic [FLAG_W-1:0] flag_wr_data,
  input logic              sp_wr_en,
  input logic [DATA_W-1:0] sp_wr_data,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] flag_save,
  input logic [DATA_W-1:0] sp_out
);
  AST_ALU_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_take && !ack_evt) |=> (flags[FB_C] == $past(alu_carry)) &&
      (flags[FB_Z] == ($past(alu_result) == '0)) &&
      (flags[FB_S] == $past(alu_result[DATA_W-1])) &&
      (flags[FB_O] == $past(alu_ovf))); // R2

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_en && !ack_evt) |=> flags == ($past(flag_wr_data) & 11'h0FD)); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[FB_D] && (flags[10:8] == 3'b000)); // R4

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> !flags[FB_I] && !flags[FB_U]); // R5

  AST_SAVE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> flag_save == $past(flags)); // R6

  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_evt |=> $stable(flag_save)); // R6

  AST_SP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_wr_en && !flag_wr_en && !ack_evt) |=> sp_out == $past(sp_wr_data)); // R9
endmodule

bind cpu_state_unit cpu_state_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .alu_take(alu_take), .ack_evt(ack_evt),
  .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
  .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
  .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data),
  .flags(flags), .flag_save(flag_save), .sp_out(sp_out)
);

// File: tb/cpu_state_unit_tb.sv
module cpu_state_unit_tb_top;
  localparam int DW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          alu_upd = 0, alu_carry = 0, alu_ovf = 0;
  logic [DW-1:0] alu_result = '0;
  logic          flag_wr_en = 0;
  logic [10:0]   flag_wr_data = '0;
  logic          int_ack = 0, wr_en = 0, pair_wr_en = 0, sp_wr_en = 0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [DW-1:0] wr_data = '0, sp_wr_data = '0;
  logic [2*DW-1:0] pair_wr_data = '0;
  logic [DW-1:0] rd_data, sp_out;
  logic [2*DW-1:0] pair_rd_data;
  logic [10:0]   flags, flag_save;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  cpu_state_unit #(.DATA_W(16), .NUM_GPR(4)) dut_i (
    .clk, .rst_n, .alu_upd, .alu_result, .alu_carry, .alu_ovf,
    .flag_wr_en, .flag_wr_data, .int_ack, .wr_en, .wr_idx, .wr_data,
    .pair_wr_en, .pair_wr_data, .rd_idx, .sp_wr_en, .sp_wr_data,
    .rd_data, .pair_rd_data, .flags, .flag_save, .sp_out
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive after a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic tick();
    @(negedge clk);
    alu_upd = 0; flag_wr_en = 0; int_ack = 0; wr_en = 0; pair_wr_en = 0; sp_wr_en = 0;
  endtask

  task automatic set_flags(logic [10:0] v);
    flag_wr_en = 1; flag_wr_data = v; tick();
  endtask

  // {result[16], carry, ovf, expected flags[11]}, starting from flags 0x0D0
  localparam logic [28:0] VEC [6] = '{
    {16'h0000, 1'b0, 1'b0, 11'h0D4},
    {16'h8000, 1'b1, 1'b0, 11'h0D9},
    {16'h7FFF, 1'b0, 1'b1, 11'h0F0},
    {16'hFFFF, 1'b1, 1'b1, 11'h0F9},
    {16'h0000, 1'b1, 1'b1, 11'h0F5},
    {16'h0001, 1'b0, 1'b0, 11'h0D0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", 32'(flags), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 flags", 32'(flags), 0);
    check("R1 flag_save", 32'(flag_save), 0);
    check("R1 sp_out", 32'(sp_out), 0);
    check("R1 rd_data", 32'(rd_data), 0);
    check("R1 pair_rd_data", pair_rd_data, 0);

    // R4: debug and reserved bits ignored
    set_flags(11'h7FF);
    check("R4 masked write", 32'(flags), 32'h0FD);

    // R3: explicit write beats ALU update
    flag_wr_en = 1; flag_wr_data = 11'h0D0;
    alu_upd = 1; alu_result = '0; alu_carry = 1; alu_ovf = 1;
    tick();
    check("R3 write wins", 32'(flags), 32'h0D0);

    // R2: ALU table
    for (int k = 0; k < 6; k++) begin
      alu_upd = 1;
      alu_result = VEC[k][28:13];
      alu_carry = VEC[k][12];
      alu_ovf = VEC[k][11];
      tick();
      check($sformatf("R2 alu vector %0d", k), 32'(flags), 32'(VEC[k][10:0]));
    end

    // R5/R6: acknowledge against a flag write in the same cycle
    int_ack = 1; flag_wr_en = 1; flag_wr_data = 11'h0C5;
    tick();
    check("R5 ack clears I,U", 32'(flags), 32'h005);
    check("R6 saved pre-ack", 32'(flag_save), 32'h0D0);
    set_flags(11'h0C0);
    check("R6 save held", 32'(flag_save), 32'h0D0);
    int_ack = 1; tick();
    check("R5 ack alone", 32'(flags), 32'h000);
    check("R6 second save", 32'(flag_save), 32'h0C0);

    // R9: stack pointer select
    sp_wr_en = 1; sp_wr_data = 16'h1234; tick();
    check("R9 isp write", 32'(sp_out), 32'h1234);
    set_flags(11'h080);
    check("R9 usp untouched", 32'(sp_out), 0);
    sp_wr_en = 1; sp_wr_data = 16'hBEEF; tick();
    check("R9 usp write", 32'(sp_out), 32'hBEEF);
    set_flags(11'h000);
    check("R9 isp kept", 32'(sp_out), 32'h1234);

    // R7: bank select
    wr_en = 1; wr_idx = 0; wr_data = 16'h1111; rd_idx = 0; tick();
    check("R7 bank0 write", 32'(rd_data), 32'h1111);
    set_flags(11'h010);
    check("R7 bank1 empty", 32'(rd_data), 0);
    wr_en = 1; wr_idx = 0; wr_data = 16'h2222; tick();
    check("R7 bank1 write", 32'(rd_data), 32'h2222);
    set_flags(11'h000);
    check("R7 bank0 kept", 32'(rd_data), 32'h1111);

    // R8: address pair and index range
    pair_wr_en = 1; pair_wr_data = 32'hAAAA5555;
    wr_en = 1; wr_idx = 4; wr_data = 16'h9999; tick();
    check("R8 pair read", pair_rd_data, 32'hAAAA5555);
    rd_idx = 4; @(negedge clk);
    check("R8 lo index", 32'(rd_data), 32'h5555);
    rd_idx = 5; @(negedge clk);
    check("R8 hi index", 32'(rd_data), 32'hAAAA);
    wr_en = 1; wr_idx = 6; wr_data = 16'h7777; rd_idx = 6; tick();
    check("R8 out of range read", 32'(rd_data), 0);
    rd_idx = 0; @(negedge clk);
    check("R8 r0 untouched", 32'(rd_data), 32'h1111);
    check("R8 pair untouched", pair_rd_data, 32'hAAAA5555);
    set_flags(11'h010);
    check("R8 R7 bank1 pair empty", pair_rd_data, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule